// File: doc/BRIEF.md
# Serial host to single-wire bus mode controller

This block sits between a host-side UART and the two engines that drive a single-wire device bus: a byte-transmit engine, which turns one byte into bus time slots and returns the byte read back, and a command executor, which runs bus resets, single time slots, pulses and parameter accesses. Each byte received from the host is given a meaning that depends on the current mode. In Command mode a byte is a command. In Data mode a byte is payload for the bus. Check mode is a one-byte transient state entered from Data mode when the escape code arrives.

Escape codes travel in-band. Sending the Command-mode escape twice in Data mode puts that value on the bus once, so that any value can reach the bus. A received character whose stop bit reads low is taken as a master reset, which returns the block to its power-on state. The block decides which host bytes earn a response byte. It holds at most one outstanding response for the UART transmitter, and it reports a device arriving on the bus when it is idle in Command mode.

States: `ST_CALIB` (after reset, waiting for the calibration byte), `ST_COMMAND`, `ST_DATA`, `ST_CHECK`, `ST_BUS_WAIT` (byte engine busy), `ST_EXEC_WAIT` (executor busy), `ST_PULSE_WAIT` (pulse running). Transitions: CALIB→EXEC_WAIT on the first byte. COMMAND→DATA on E1h. COMMAND→EXEC_WAIT on a legal non-pulse command. COMMAND→PULSE_WAIT on a pulse command. DATA→CHECK on E3h. DATA→BUS_WAIT on any other byte. CHECK→BUS_WAIT on a second E3h. CHECK→(command routing) on any other byte. BUS_WAIT→DATA on byte done. EXEC_WAIT and PULSE_WAIT→COMMAND on command done. Any state→CALIB on master reset.

Top module: `swb_mode_ctrl`

## Requirements
- R1: After rst_n or a master reset, rx_ready is 1, tx_valid is 0 and no request is issued; the block waits in the calibration state, which counts as Command mode.
- R2: The first byte after any reset is passed to the command executor (cmd_req, cmd_code equal to the byte) whatever its value, and it produces no response byte.
- R3: In Command mode, E1h moves the block to Data mode and E3h leaves it in Command mode; neither byte is dispatched to an engine or answered.
- R4: In Data mode, every byte other than E3h is issued to the byte engine (byte_req, byte_data equal to the byte), and the byte_result it returns is sent to the host as the response.
- R5: In Data mode, E3h followed by E3h sends a single E3h to the byte engine, returns its result, and leaves the block in Data mode.
- R6: In Data mode, E3h followed by any other byte executes that byte as a command, and the block continues in Command mode.
- R7: Command classes: bit 7 = 0 is a configuration command, legal only when bit 0 = 1; bit 7 = 1 is a communication command whose bits 6:5 select 01 = search-assist control (dispatched, no response), 11 = pulse, 00 or 10 = dispatched with one response. An illegal byte is neither dispatched nor answered. Every other legal command returns cmd_result as exactly one response.
- R8: While a pulse runs, F1h raises pulse_stop for one cycle, and every other received byte is discarded. The pulse response is sent when cmd_done arrives. F1h outside a pulse has no effect.
- R9: A framing-error strobe with rx_stop_level = 0 forces a master reset from any state. With rx_stop_level = 1 it is ignored.
- R10: presence_evt in idle Command mode with no response pending sends the byte 01h (undefined bits 0). It is dropped in Data mode or while a response is pending.
- R11: Received bytes are held in a one-entry buffer. rx_ready is 0 while that buffer is occupied.
- R12: A response stays on tx_data, with tx_valid high, until tx_ready takes it. No new byte is dispatched while a response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | UART receiver has a byte |
| rx_data | input | 8 | Received byte |
| rx_ferr | input | 1 | Framing-error strobe |
| rx_stop_level | input | 1 | Sampled stop-bit level of the errored character |
| rx_ready | output | 1 | Block can take a received byte |
| byte_req | output | 1 | One-cycle request to the byte engine |
| byte_data | output | 8 | Byte to place on the bus |
| byte_done | input | 1 | Byte engine finished |
| byte_result | input | 8 | Byte read back from the bus |
| cmd_req | output | 1 | One-cycle request to the command executor |
| cmd_code | output | 8 | Command byte to execute |
| cmd_done | input | 1 | Command executor finished |
| cmd_result | input | 8 | Response byte from the executor |
| pulse_stop | output | 1 | One-cycle request to end a running pulse |
| presence_evt | input | 1 | Unsolicited presence pulse seen on the bus |
| tx_valid | output | 1 | Response byte available |
| tx_data | output | 8 | Response byte |
| tx_ready | input | 1 | UART transmitter takes the response |

## Verification
Command mode is tried with every class of byte: configuration bytes with bit 0 clear and set, each communication function, and the three escape codes. This tells apart a dispatch with a response, a dispatch without one, and a byte that is dropped. Data mode is tried with ordinary payload, a doubled escape and an escape followed by a command, which separates the bus path from the command path in Check mode. Pulses are ended by F1h, ended by the executor alone, and fed with stray bytes, which shows that only F1h reaches pulse_stop. Framing errors with each stop-bit level, presence events in each mode, and a stalled transmitter show reset recovery, arrival filtering and the response gate.

// File: rtl/swb_mode_pkg.sv
package swb_mode_pkg;

    typedef enum logic [2:0] {
        ST_CALIB,
        ST_COMMAND,
        ST_DATA,
        ST_CHECK,
        ST_BUS_WAIT,
        ST_EXEC_WAIT,
        ST_PULSE_WAIT
    } mc_state_e;

    typedef enum logic [2:0] {
        CC_TO_DATA,
        CC_TO_CMD,
        CC_PULSE_END,
        CC_ILLEGAL,
        CC_ASSIST,
        CC_PULSE,
        CC_PLAIN
    } cmd_class_e;

endpackage

// File: rtl/swb_rx_hold.sv
// One-entry holding register between the UART receiver and the mode FSM.
module swb_rx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] data
);
    logic accept;
    assign accept = in_valid && !full && !clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
        end else if (clr || take) begin
            full <= 1'b0;
        end else if (accept) begin
            full <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
        end else if (accept) begin
            data <= in_data;
        end
    end
endmodule

// File: rtl/swb_cmd_decode.sv
// Classifies a command-mode byte; reserved escapes win over the bit fields.
module swb_cmd_decode
    import swb_mode_pkg::*;
#(
    parameter int            W           = 8,
    parameter logic [W-1:0]  CODE_DATA   = 8'hE1,
    parameter logic [W-1:0]  CODE_CMD    = 8'hE3,
    parameter logic [W-1:0]  CODE_PEND   = 8'hF1
) (
    input  logic [W-1:0] byte_in,
    output cmd_class_e   cls
);
    localparam int MSB = W - 1;

    always_comb begin
        if (byte_in == CODE_DATA) begin
            cls = CC_TO_DATA;
        end else if (byte_in == CODE_CMD) begin
            cls = CC_TO_CMD;
        end else if (byte_in == CODE_PEND) begin
            cls = CC_PULSE_END;
        end else if (!byte_in[MSB]) begin
            // configuration access: legal only with the low bit set
            cls = byte_in[0] ? CC_PLAIN : CC_ILLEGAL;
        end else begin
            unique case (byte_in[MSB-1:MSB-2])
                2'b01:   cls = CC_ASSIST;
                2'b11:   cls = CC_PULSE;
                default: cls = CC_PLAIN;
            endcase
        end
    end
endmodule

// File: rtl/swb_resp_slot.sv
// Single response register toward the UART transmitter.
module swb_resp_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         tx_ready,
    output logic         tx_valid,
    output logic [W-1:0] tx_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else if (clr) begin
            tx_valid <= 1'b0;
        end else if (load) begin
            tx_valid <= 1'b1;
            tx_data  <= load_data;
        end else if (tx_valid && tx_ready) begin
            tx_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/swb_mode_ctrl.sv
module swb_mode_ctrl
    import swb_mode_pkg::*;
#(
    parameter int                 BYTE_W    = 8,
    parameter logic [BYTE_W-1:0]  CODE_DATA = 8'hE1,
    parameter logic [BYTE_W-1:0]  CODE_CMD  = 8'hE3,
    parameter logic [BYTE_W-1:0]  CODE_PEND = 8'hF1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_ferr,
    input  logic              rx_stop_level,
    output logic              rx_ready,
    output logic              byte_req,
    output logic [BYTE_W-1:0] byte_data,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] byte_result,
    output logic              cmd_req,
    output logic [BYTE_W-1:0] cmd_code,
    input  logic              cmd_done,
    input  logic [BYTE_W-1:0] cmd_result,
    output logic              pulse_stop,
    input  logic              presence_evt,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready
);
    localparam logic [BYTE_W-1:0] ARRIVAL = {{(BYTE_W-2){1'b0}}, 2'b01};

    mc_state_e         st, nxt;
    logic              resp_en, nxt_resp_en;
    logic              mres;
    logic              hold_full;
    logic [BYTE_W-1:0] hold_data;
    logic              take;
    logic              can_go;
    logic              ld;
    logic [BYTE_W-1:0] ld_data;
    logic              byte_go, cmd_go, stop_go;
    cmd_class_e        cls;
    mc_state_e         route_nxt;
    logic              route_issue, route_resp;

    // start polarity where the stop bit belongs: full master reset
    assign mres = rx_ferr && !rx_stop_level;

    swb_rx_hold #(.W(BYTE_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (mres),
        .in_valid (rx_valid),
        .in_data  (rx_data),
        .take     (take),
        .full     (hold_full),
        .data     (hold_data)
    );

    swb_cmd_decode #(
        .W         (BYTE_W),
        .CODE_DATA (CODE_DATA),
        .CODE_CMD  (CODE_CMD),
        .CODE_PEND (CODE_PEND)
    ) u_dec (
        .byte_in (hold_data),
        .cls     (cls)
    );

    swb_resp_slot #(.W(BYTE_W)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (mres),
        .load      (ld),
        .load_data (ld_data),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data)
    );

    // Where a byte treated as a command leads.
    always_comb begin
        route_nxt   = ST_COMMAND;
        route_issue = 1'b0;
        route_resp  = 1'b0;
        unique case (cls)
            CC_TO_DATA:   route_nxt = ST_DATA;
            CC_TO_CMD,
            CC_PULSE_END,
            CC_ILLEGAL:   route_nxt = ST_COMMAND;
            CC_ASSIST: begin
                route_nxt   = ST_EXEC_WAIT;
                route_issue = 1'b1;
            end
            CC_PULSE: begin
                route_nxt   = ST_PULSE_WAIT;
                route_issue = 1'b1;
                route_resp  = 1'b1;
            end
            CC_PLAIN: begin
                route_nxt   = ST_EXEC_WAIT;
                route_issue = 1'b1;
                route_resp  = 1'b1;
            end
            default:      route_nxt = ST_COMMAND;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_CALIB;
            resp_en <= 1'b0;
        end else if (mres) begin
            st      <= ST_CALIB;
            resp_en <= 1'b0;
        end else begin
            st      <= nxt;
            resp_en <= nxt_resp_en;
        end
    end

    // Next state and outputs.
    assign can_go = hold_full && !tx_valid;

    always_comb begin
        nxt         = st;
        nxt_resp_en = resp_en;
        take        = 1'b0;
        byte_go     = 1'b0;
        cmd_go      = 1'b0;
        stop_go     = 1'b0;
        ld          = 1'b0;
        ld_data     = '0;
        unique case (st)
            ST_CALIB: begin
                if (can_go) begin
                    take        = 1'b1;
                    cmd_go      = 1'b1;
                    nxt_resp_en = 1'b0;
                    nxt         = ST_EXEC_WAIT;
                end
            end
            ST_COMMAND: begin
                if (presence_evt && !tx_valid) begin
                    ld      = 1'b1;
                    ld_data = ARRIVAL;
                end
                if (can_go) begin
                    take        = 1'b1;
                    cmd_go      = route_issue;
                    nxt_resp_en = route_resp;
                    nxt         = route_nxt;
                end
            end
            ST_DATA: begin
                if (can_go) begin
                    take = 1'b1;
                    if (hold_data == CODE_CMD) begin
                        nxt = ST_CHECK;
                    end else begin
                        byte_go = 1'b1;
                        nxt     = ST_BUS_WAIT;
                    end
                end
            end
            ST_CHECK: begin
                if (can_go) begin
                    take = 1'b1;
                    if (hold_data == CODE_CMD) begin
                        byte_go = 1'b1;
                        nxt     = ST_BUS_WAIT;
                    end else begin
                        cmd_go      = route_issue;
                        nxt_resp_en = route_resp;
                        nxt         = route_nxt;
                    end
                end
            end
            ST_BUS_WAIT: begin
                if (byte_done) begin
                    ld      = 1'b1;
                    ld_data = byte_result;
                    nxt     = ST_DATA;
                end
            end
            ST_EXEC_WAIT: begin
                if (cmd_done) begin
                    ld      = resp_en;
                    ld_data = cmd_result;
                    nxt     = ST_COMMAND;
                end
            end
            ST_PULSE_WAIT: begin
                if (hold_full) begin
                    take    = 1'b1;
                    stop_go = (cls == CC_PULSE_END);
                end
                if (cmd_done) begin
                    ld      = 1'b1;
                    ld_data = cmd_result;
                    nxt     = ST_COMMAND;
                end
            end
            default: nxt = ST_CALIB;
        endcase
        if (mres) begin
            take    = 1'b0;
            byte_go = 1'b0;
            cmd_go  = 1'b0;
            stop_go = 1'b0;
            ld      = 1'b0;
        end
    end

    assign rx_ready   = !hold_full;
    assign byte_req   = byte_go;
    assign byte_data  = hold_data;
    assign cmd_req    = cmd_go;
    assign cmd_code   = hold_data;
    assign pulse_stop = stop_go;
endmodule

// File: rtl/swb_mode_ctrl_chk.sv
module swb_mode_ctrl_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              rx_ferr,
    input logic              rx_stop_level,
    input logic              byte_req,
    input logic              cmd_req,
    input logic              pulse_stop,
    input logic              tx_valid,
    input logic [BYTE_W-1:0] tx_data,
    input logic              tx_ready
);
    logic mres;
    assign mres = rx_ferr && !rx_stop_level;

    assert_hold_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && !mres) |=> !rx_ready);

    assert_resp_kept_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !mres) |=> (tx_valid && $stable(tx_data)));

    assert_no_dispatch_pending_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_req || cmd_req) |-> !tx_valid);

    assert_one_engine_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_req && cmd_req) && !(byte_req && pulse_stop));

    assert_master_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mres |=> (rx_ready && !tx_valid && !byte_req && !cmd_req && !pulse_stop));
endmodule

bind swb_mode_ctrl swb_mode_ctrl_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_valid      (rx_valid),
    .rx_ready      (rx_ready),
    .rx_ferr       (rx_ferr),
    .rx_stop_level (rx_stop_level),
    .byte_req      (byte_req),
    .cmd_req       (cmd_req),
    .pulse_stop    (pulse_stop),
    .tx_valid      (tx_valid),
    .tx_data       (tx_data),
    .tx_ready      (tx_ready)
);

// File: tb/swb_mode_ctrl_bench.sv
`timescale 1ns/1ps
module swb_mode_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_ferr = 1'b0;
    logic       rx_stop_level = 1'b1;
    logic       rx_ready;
    logic       byte_req;
    logic [7:0] byte_data;
    logic       byte_done = 1'b0;
    logic [7:0] byte_result = 8'h00;
    logic       cmd_req;
    logic [7:0] cmd_code;
    logic       cmd_done = 1'b0;
    logic [7:0] cmd_result = 8'h00;
    logic       pulse_stop;
    logic       presence_evt = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b1;

    always #10 clk = ~clk;

    swb_mode_ctrl u_swb_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ferr(rx_ferr), .rx_stop_level(rx_stop_level), .rx_ready(rx_ready),
        .byte_req(byte_req), .byte_data(byte_data), .byte_done(byte_done),
        .byte_result(byte_result), .cmd_req(cmd_req), .cmd_code(cmd_code),
        .cmd_done(cmd_done), .cmd_result(cmd_result), .pulse_stop(pulse_stop),
        .presence_evt(presence_evt), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int n_stop  = 0;
    int n_cmd   = 0;
    bit finished = 1'b0;

    logic [7:0] exp_bus[$];
    logic [7:0] exp_cmd[$];
    logic [7:0] exp_tx[$];

    // reference model state: 0 calib, 1 command, 2 data, 3 check
    int  m_mode = 0;
    bit  pulse_on = 1'b0;

    task automatic chk(input bit ok, input string req,
                       input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // 0 to data, 1 no effect, 2 assist (no reply), 3 pulse, 4 reply
    function automatic int bclass(input logic [7:0] b);
        if (b == 8'hE1) return 0;
        if (b == 8'hE3 || b == 8'hF1) return 1;
        if (!b[7]) return b[0] ? 4 : 1;
        if (b[6:5] == 2'b01) return 2;
        if (b[6:5] == 2'b11) return 3;
        return 4;
    endfunction

    task automatic model_cmd(input logic [7:0] b);
        m_mode = 1;
        case (bclass(b))
            0: m_mode = 2;
            2: exp_cmd.push_back(b);
            3: begin exp_cmd.push_back(b); exp_tx.push_back(b ^ 8'h5A); pulse_on = 1'b1; end
            4: begin exp_cmd.push_back(b); exp_tx.push_back(b ^ 8'h5A); end
            default: ;
        endcase
    endtask

    task automatic model_byte(input logic [7:0] b);
        if (pulse_on) return;
        case (m_mode)
            0: begin exp_cmd.push_back(b); m_mode = 1; end
            2: begin
                if (b == 8'hE3) m_mode = 3;
                else begin exp_bus.push_back(b); exp_tx.push_back(~b); end
            end
            3: begin
                if (b == 8'hE3) begin
                    exp_bus.push_back(b); exp_tx.push_back(~b); m_mode = 2;
                end else model_cmd(b);
            end
            default: model_cmd(b);
        endcase
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send(input logic [7:0] b);
        while (!rx_ready) step(1);
        rx_valid = 1'b1;
        rx_data  = b;
        model_byte(b);
        step(1);
        rx_valid = 1'b0;
    endtask

    task automatic framing(input logic lvl);
        rx_ferr = 1'b1;
        rx_stop_level = lvl;
        if (!lvl) begin m_mode = 0; pulse_on = 1'b0; end
        step(1);
        rx_ferr = 1'b0;
        rx_stop_level = 1'b1;
    endtask

    task automatic presence(input bit expect_report);
        presence_evt = 1'b1;
        if (expect_report) exp_tx.push_back(8'h01);
        step(1);
        presence_evt = 1'b0;
    endtask

    // byte engine: result is the inverted byte, three cycles later
    initial begin
        logic [7:0] r;
        forever begin
            @(posedge clk); #1;
            if (byte_req) begin
                r = ~byte_data;
                repeat (3) @(posedge clk);
                #1 byte_done = 1'b1; byte_result = r;
                @(posedge clk); #1 byte_done = 1'b0;
            end
        end
    end

    // command executor: result is code ^ 5Ah; pulses wait for a stop or 30 cycles
    initial begin
        logic [7:0] c;
        forever begin
            @(posedge clk); #1;
            if (cmd_req) begin
                c = cmd_code;
                if (c[7] && c[6:5] == 2'b11) begin
                    for (int k = 0; k < 30; k++) begin
                        @(posedge clk); #1;
                        if (pulse_stop) break;
                    end
                end else begin
                    repeat (3) @(posedge clk);
                    #1;
                end
                cmd_done = 1'b1; cmd_result = c ^ 8'h5A;
                @(posedge clk); #1 cmd_done = 1'b0;
            end
        end
    end

    // per-clock comparison of every strobe against the model queues
    logic [7:0] e_b, e_c, e_t;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pulse_stop) n_stop++;
            if (byte_req) begin
                if (exp_bus.size() == 0) chk(1'b0, "R4 unexpected bus byte", byte_data, 8'h00);
                else begin e_b = exp_bus.pop_front(); chk(byte_data == e_b, "R4 bus byte", byte_data, e_b); end
            end
            if (cmd_req) begin
                n_cmd++;
                if (exp_cmd.size() == 0) chk(1'b0, "R7 unexpected command", cmd_code, 8'h00);
                else begin e_c = exp_cmd.pop_front(); chk(cmd_code == e_c, "R7 command code", cmd_code, e_c); end
            end
            if (tx_valid && tx_ready) begin
                if (exp_tx.size() == 0) chk(1'b0, "R12 unexpected response", tx_data, 8'h00);
                else begin e_t = exp_tx.pop_front(); chk(tx_data == e_t, "R12 response byte", tx_data, e_t); end
            end
        end
    end

    task automatic drained(input string req);
        chk(exp_bus.size() == 0, req, 8'(exp_bus.size()), 8'h00);
        chk(exp_cmd.size() == 0, req, 8'(exp_cmd.size()), 8'h00);
        chk(exp_tx.size()  == 0, req, 8'(exp_tx.size()),  8'h00);
    endtask

    initial begin
        int c0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk(rx_ready == 1'b1, "R1 rx_ready after reset", {7'd0, rx_ready}, 8'h01);
        chk(tx_valid == 1'b0, "R1 no response after reset", {7'd0, tx_valid}, 8'h00);
        chk(!byte_req && !cmd_req, "R1 no request after reset", {6'd0, byte_req, cmd_req}, 8'h00);

        // R2 calibration byte
        send(8'hC1); step(12);
        drained("R2 calibration byte dispatched, no reply");

        // R7 command classes
        send(8'h81); step(12);
        send(8'hA1); step(12);
        send(8'h10); step(12);
        send(8'h11); step(12);
        drained("R7 command classes");
        // R3 E3h in command mode, R8 F1h outside a pulse
        send(8'hE3); step(6);
        send(8'hF1); step(6);
        chk(n_stop == 0, "R8 stray F1 no stop", 8'(n_stop), 8'h00);
        drained("R3 E3h in command mode silent");

        // R10 arrival in idle command mode
        presence(1'b1); step(6);
        drained("R10 arrival report 01h");

        // R3 to data mode, R4 payload, R11 buffer
        send(8'hE1); step(4);
        drained("R3 E1h silent");
        send(8'h3C);
        send(8'hA5);
        chk(rx_ready == 1'b0, "R11 buffer holds byte", {7'd0, rx_ready}, 8'h00);
        step(20);
        drained("R4 data bytes forwarded");
        presence(1'b0); step(6);
        drained("R10 no arrival in data mode");

        // R5 doubled escape
        send(8'hE3); send(8'hE3); step(12);
        send(8'h00); step(12);
        drained("R5 doubled escape");

        // R6 escape then command
        send(8'hE3); send(8'h81); step(12);
        send(8'h55); step(12);
        drained("R6 escape then command");

        // R8 pulses
        send(8'hEF); step(6); send(8'hF1); step(12);
        pulse_on = 1'b0;
        chk(n_stop == 1, "R8 F1 stops pulse", 8'(n_stop), 8'h01);
        send(8'hED); step(45);
        pulse_on = 1'b0;
        chk(n_stop == 1, "R8 pulse ends without F1", 8'(n_stop), 8'h01);
        c0 = n_cmd;
        send(8'hEB); step(4); send(8'h81); send(8'hF1); step(12);
        pulse_on = 1'b0;
        chk(n_stop == 2, "R8 stray byte in pulse", 8'(n_stop), 8'h02);
        chk(n_cmd == c0 + 1, "R8 stray byte discarded", 8'(n_cmd - c0), 8'h01);
        drained("R8 pulse responses");

        // R12 response pending
        tx_ready = 1'b0;
        send(8'h81); step(12);
        c0 = n_cmd;
        send(8'h85); step(12);
        chk(n_cmd == c0, "R12 no dispatch while pending", 8'(n_cmd - c0), 8'h00);
        chk(tx_valid == 1'b1 && tx_data == 8'hDB, "R12 response held", tx_data, 8'hDB);
        presence(1'b0); step(4);
        chk(tx_data == 8'hDB, "R10 arrival dropped while pending", tx_data, 8'hDB);
        tx_ready = 1'b1; step(16);
        drained("R12 pending released");

        // R9 framing errors
        send(8'hE1); step(4);
        framing(1'b1); step(2);
        send(8'h66); step(12);
        drained("R9 high stop bit ignored");
        framing(1'b0);
        chk(rx_ready == 1'b1, "R9 ready after master reset", {7'd0, rx_ready}, 8'h01);
        chk(tx_valid == 1'b0, "R1 no response after master reset", {7'd0, tx_valid}, 8'h00);
        send(8'hC5); step(12);
        send(8'h81); step(12);
        drained("R9 calibration after master reset");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule